// File: doc/BRIEF.md
# Interrupt Acknowledge Arbiter

This block decides which interrupt source answers a processor interrupt acknowledge cycle. Every source holds a 4-bit arbitration number. Source 0 is the integration module. It stands for its own periodic timer and for the external interrupt pins. Sources 1 to NMOD are internal modules, and each presents a 3-bit request level and an 8-bit vector. An acknowledge cycle is a `cyc_start` strobe carrying function code 3'b111 and the level being acknowledged. Contention then runs among every source that requests at that level, even when only one source is requesting.

An internal winner ends the cycle at once with its own vector. If the integration module wins, its periodic timer is served first when it requests at that level. Otherwise the cycle is forwarded to the external side, and `ext_req` is held high. The external side can end a forwarded cycle in three ways: a vector with a data acknowledge, an autovector request, or a programmed chip-select autovector. When none of these arrives within the bus-monitor window, the cycle ends in a bus error and is reported as spurious.

Top module: `iack_arbiter`

## Requirements
- R1: After reset, the arbitration number of source 0 is 15 and that of every module is 0. Writing `cfg_arb` with `cfg_we` at index `cfg_idx` (0 = integration module, i = module i) changes the number used from the next cycle.
- R2: A source contends only if it requests at the acknowledged level (nonzero) and its arbitration number is nonzero. If nothing contends, the cycle ends one cycle after the start with `done` and `berr` high.
- R3: Among contenders, the highest arbitration number wins. A winning module i ends the cycle one cycle after the start with `done` high and `vec_out` equal to its vector. `ext_req` stays low.
- R4: If two or more contenders share the highest number, the cycle ends one cycle after the start with `done`, `berr` and `dup_err` all high.
- R5: Source 0 requests at a level if `pit_lvl` or `irq_lvl` equals it. When source 0 wins and `pit_lvl` matches, the cycle ends internally with `vec_out` = `pit_vec`, and `ext_req` stays low.
- R6: When source 0 wins without a periodic timer match, `ext_req` rises one cycle after the start. A cycle in which `ext_dsack` is sampled high ends the transfer on the next cycle, with `vec_out` = `ext_data`.
- R7: On a forwarded cycle, `ext_avec` ends the transfer with `vec_out` = 24 + level. A data acknowledge sampled in the same cycle takes precedence over it.
- R8: If a forwarded cycle receives no response during TIMEOUT cycles of `ext_req`, it ends with `done`, `berr` and `spurious` high and `vec_out` = 24.
- R9: When `cs_en` is set and `cs_lvl` equals the level, a forwarded cycle ends with autovector 24 + level. The chip-select has no effect when a module wins.
- R10: A `cyc_start` whose `fc` is not 3'b111 is ignored. So is a start that arrives while a forwarded cycle is pending.
- R11: `pit_lvl` = 0 means the periodic timer never requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Arbitration number write strobe |
| cfg_idx | input | IDXW | Source index to write |
| cfg_arb | input | 4 | Arbitration number value |
| cyc_start | input | 1 | Acknowledge cycle start strobe |
| fc | input | 3 | Function code of the cycle |
| ack_lvl | input | 3 | Level being acknowledged |
| mod_lvl | input | 3*NMOD | Request level of each module (module i at slice i-1) |
| mod_vec | input | 8*NMOD | Vector of each module |
| pit_lvl | input | 3 | Periodic timer level, 0 = off |
| pit_vec | input | 8 | Periodic timer vector |
| irq_lvl | input | 3 | Highest level pending on external pins, 0 = none |
| cs_en | input | 1 | Chip-select autovector enable |
| cs_lvl | input | 3 | Level the chip-select answers |
| ext_dsack | input | 1 | External data acknowledge |
| ext_avec | input | 1 | External autovector request |
| ext_data | input | 8 | External vector |
| ext_req | output | 1 | Cycle forwarded to the external bus |
| done | output | 1 | Cycle termination pulse |
| vec_out | output | 8 | Vector, valid with done |
| berr | output | 1 | Bus error, with done |
| spurious | output | 1 | Timeout on a forwarded cycle, with done |
| dup_err | output | 1 | Tied top arbitration numbers, with done |

## Verification
The bench builds the block with NMOD = 3 and TIMEOUT = 8. Three modules are enough to produce ties beside a clear winner. The short window lets every timeout and every late external response be reached within a few cycles.

// File: rtl/iack_arbiter.sv
module iack_arbiter #(
  parameter int NMOD = 3,
  parameter int TIMEOUT = 64,
  localparam int IDXW = $clog2(NMOD + 1),
  localparam int CW = $clog2(TIMEOUT) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDXW-1:0]   cfg_idx,
  input  logic [3:0]        cfg_arb,
  input  logic              cyc_start,
  input  logic [2:0]        fc,
  input  logic [2:0]        ack_lvl,
  input  logic [3*NMOD-1:0] mod_lvl,
  input  logic [8*NMOD-1:0] mod_vec,
  input  logic [2:0]        pit_lvl,
  input  logic [7:0]        pit_vec,
  input  logic [2:0]        irq_lvl,
  input  logic              cs_en,
  input  logic [2:0]        cs_lvl,
  input  logic              ext_dsack,
  input  logic              ext_avec,
  input  logic [7:0]        ext_data,
  output logic              ext_req,
  output logic              done,
  output logic [7:0]        vec_out,
  output logic              berr,
  output logic              spurious,
  output logic              dup_err
);

  logic [3:0]      arb [NMOD+1];
  logic            fwd;
  logic [2:0]      lvl;
  logic [CW-1:0]   cnt;
  logic [3:0]      best;
  logic [IDXW:0]   nbest;
  logic            sim_win;
  logic [7:0]      win_vec;

  wire sim_req = (ack_lvl != 3'd0) && (pit_lvl == ack_lvl || irq_lvl == ack_lvl);
  wire pit_hit = (ack_lvl != 3'd0) && (pit_lvl == ack_lvl);
  wire start   = cyc_start && fc == 3'b111 && !fwd;
  wire cs_hit  = cs_en && cs_lvl == lvl;
  wire [7:0] autovec = 8'd24 + {5'd0, lvl};

  always_comb begin
    best = 4'd0;
    nbest = '0;
    sim_win = 1'b0;
    win_vec = 8'd0;
    for (int i = 0; i <= NMOD; i++) begin
      logic rq;
      if (i == 0) rq = sim_req;
      else        rq = (ack_lvl != 3'd0) && (mod_lvl[3*(i-1) +: 3] == ack_lvl);
      if (rq && arb[i] != 4'd0) begin
        if (arb[i] > best) begin
          best = arb[i];
          nbest = 1;
          sim_win = (i == 0);
          win_vec = (i == 0) ? pit_vec : mod_vec[8*((i > 0) ? i-1 : 0) +: 8];
        end else if (arb[i] == best) begin
          nbest = nbest + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= NMOD; i++) arb[i] <= (i == 0) ? 4'hF : 4'h0;
    end else if (cfg_we && int'(cfg_idx) <= NMOD) begin
      arb[cfg_idx] <= cfg_arb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd <= 1'b0; lvl <= 3'd0; cnt <= '0;
      done <= 1'b0; vec_out <= 8'd0; berr <= 1'b0; spurious <= 1'b0; dup_err <= 1'b0;
    end else begin
      done <= 1'b0; berr <= 1'b0; spurious <= 1'b0; dup_err <= 1'b0;
      if (start) begin
        if (nbest == 0) begin
          done <= 1'b1; berr <= 1'b1; vec_out <= 8'd0;
        end else if (nbest > 1) begin
          done <= 1'b1; berr <= 1'b1; dup_err <= 1'b1; vec_out <= 8'd0;
        end else if (sim_win && !pit_hit) begin
          fwd <= 1'b1; lvl <= ack_lvl; cnt <= '0;
        end else begin
          done <= 1'b1; vec_out <= win_vec;
        end
      end else if (fwd) begin
        if (ext_dsack) begin
          fwd <= 1'b0; done <= 1'b1; vec_out <= ext_data;
        end else if (ext_avec || cs_hit) begin
          fwd <= 1'b0; done <= 1'b1; vec_out <= autovec;
        end else if (cnt == CW'(TIMEOUT - 1)) begin
          fwd <= 1'b0; done <= 1'b1; berr <= 1'b1; spurious <= 1'b1; vec_out <= 8'd24;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign ext_req = fwd;

  a_r2_berr_with_done: assert property (@(posedge clk) disable iff (!rst_n) berr |-> done);
  a_r4_dup_is_berr: assert property (@(posedge clk) disable iff (!rst_n) dup_err |-> berr && !spurious);
  a_r8_spurious_vec: assert property (@(posedge clk) disable iff (!rst_n) spurious |-> berr && vec_out == 8'd24);
  a_r6_fwd_ends_done: assert property (@(posedge clk) disable iff (!rst_n) $fell(ext_req) |-> done);
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n) ext_req |=> (ext_req || done));

endmodule

// File: tb/iack_arbiter_tb.sv
module iack_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 3;
  localparam int TO = 8;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [1:0] cfg_idx = 0; logic [3:0] cfg_arb = 0;
  logic cyc_start = 0; logic [2:0] fc = 0, ack_lvl = 0;
  logic [3*NM-1:0] mod_lvl; logic [8*NM-1:0] mod_vec;
  logic [2:0] pit_lvl = 0, irq_lvl = 0, cs_lvl = 0; logic [7:0] pit_vec = 8'h50;
  logic cs_en = 0, ext_dsack = 0, ext_avec = 0; logic [7:0] ext_data = 0;
  logic ext_req, done, berr, spurious, dup_err; logic [7:0] vec_out;

  int m_lvl [NM+1];
  int m_vec [NM+1];
  always_comb for (int i = 1; i <= NM; i++) begin
    mod_lvl[3*(i-1) +: 3] = m_lvl[i][2:0];
    mod_vec[8*(i-1) +: 8] = m_vec[i][7:0];
  end

  iack_arbiter #(.NMOD(NM), .TIMEOUT(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_arb(cfg_arb),
    .cyc_start(cyc_start), .fc(fc), .ack_lvl(ack_lvl), .mod_lvl(mod_lvl), .mod_vec(mod_vec),
    .pit_lvl(pit_lvl), .pit_vec(pit_vec), .irq_lvl(irq_lvl), .cs_en(cs_en), .cs_lvl(cs_lvl),
    .ext_dsack(ext_dsack), .ext_avec(ext_avec), .ext_data(ext_data),
    .ext_req(ext_req), .done(done), .vec_out(vec_out), .berr(berr),
    .spurious(spurious), .dup_err(dup_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  string cur = "R1";
  int arb_t [NM+1];
  int fwd_m, lvl_m, cnt_m;
  int e_done, e_vec, e_berr, e_spur, e_dup;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      arb_t[0] = 15; for (int i = 1; i <= NM; i++) arb_t[i] = 0;
      fwd_m = 0; lvl_m = 0; cnt_m = 0;
      e_done = 0; e_vec = 0; e_berr = 0; e_spur = 0; e_dup = 0;
    end else begin
      e_done = 0; e_berr = 0; e_spur = 0; e_dup = 0;
      if (cyc_start && fc == 3'b111 && fwd_m == 0) begin
        int best, win, n, a;
        best = 0; win = -1; n = 0; a = int'(ack_lvl);
        for (int i = 0; i <= NM; i++) begin
          bit rq;
          rq = (i == 0) ? (a != 0 && (int'(pit_lvl) == a || int'(irq_lvl) == a))
                        : (a != 0 && m_lvl[i] == a);
          if (rq && arb_t[i] != 0) begin
            if (arb_t[i] > best) begin best = arb_t[i]; win = i; n = 1; end
            else if (arb_t[i] == best) n++;
          end
        end
        if (n == 0) begin e_done = 1; e_berr = 1; e_vec = 0; end
        else if (n > 1) begin e_done = 1; e_berr = 1; e_dup = 1; e_vec = 0; end
        else if (win == 0 && int'(pit_lvl) != a) begin fwd_m = 1; lvl_m = a; cnt_m = 0; end
        else begin e_done = 1; e_vec = (win == 0) ? int'(pit_vec) : m_vec[win]; end
      end else if (fwd_m == 1) begin
        if (ext_dsack) begin fwd_m = 0; e_done = 1; e_vec = int'(ext_data); end
        else if (ext_avec || (cs_en && int'(cs_lvl) == lvl_m)) begin fwd_m = 0; e_done = 1; e_vec = 24 + lvl_m; end
        else if (cnt_m == TO - 1) begin fwd_m = 0; e_done = 1; e_berr = 1; e_spur = 1; e_vec = 24; end
        else cnt_m++;
      end
      if (cfg_we && int'(cfg_idx) <= NM) arb_t[cfg_idx] = int'(cfg_arb);
    end
    #1;
    chk("done", int'(done), e_done);
    chk("berr", int'(berr), e_berr);
    chk("spurious", int'(spurious), e_spur);
    chk("dup_err", int'(dup_err), e_dup);
    chk("ext_req", int'(ext_req), fwd_m);
    if (e_done == 1) chk("vec_out", int'(vec_out), e_vec);
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(int idx, int v);
    @(negedge clk); cfg_we = 1; cfg_idx = 2'(idx); cfg_arb = 4'(v);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic ack(int l, int f);
    @(negedge clk); cyc_start = 1; ack_lvl = 3'(l); fc = 3'(f);
    @(negedge clk); cyc_start = 0;
  endtask

  initial begin
    for (int i = 0; i <= NM; i++) begin m_lvl[i] = 0; m_vec[i] = 64 + 16*i; end
    idle(3); rst_n = 1; idle(2);
    cur = "R2"; m_lvl[1] = 3; ack(3, 7); idle(2);
    cur = "R1"; irq_lvl = 5; ack(5, 7); idle(1);
    cur = "R6"; ext_data = 8'h8C; ext_dsack = 1; @(negedge clk); ext_dsack = 0; idle(2);
    cur = "R3"; cfg(1, 5); cfg(2, 9); m_lvl[1] = 4; m_lvl[2] = 4; ack(4, 7); idle(2);
    cur = "R4"; cfg(3, 9); m_lvl[3] = 4; ack(4, 7); idle(2);
    cur = "R5"; m_lvl[3] = 0; irq_lvl = 4; pit_lvl = 4; ack(4, 7); idle(2);
    cur = "R11"; pit_lvl = 0; irq_lvl = 0; m_lvl[1] = 0; m_lvl[2] = 0; ack(0, 7); idle(2);
    cur = "R7"; irq_lvl = 2; ack(2, 7); idle(2);
    ext_avec = 1; ext_dsack = 1; ext_data = 8'h33; @(negedge clk); ext_avec = 0; ext_dsack = 0; idle(2);
    ack(2, 7); ext_avec = 1; @(negedge clk); ext_avec = 0; idle(2);
    cur = "R9"; cs_en = 1; cs_lvl = 6; m_lvl[2] = 6; ack(6, 7); idle(2);
    m_lvl[2] = 0; irq_lvl = 6; ack(6, 7); idle(3); cs_en = 0;
    cur = "R8"; irq_lvl = 1; ack(1, 7); idle(TO + 4);
    cur = "R10"; ack(1, 5); idle(2);
    ack(1, 7); ack(1, 7); idle(TO + 4);
    cur = "R1"; cfg(0, 0); ack(1, 7); idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule